// File: doc/BRIEF.md
# Zero-Crossing Timestamp Estimator

This block turns two digitized polarity signals from an isolated line-voltage interface into one timestamp per line cycle marking the positive-going zero crossing. Both polarity inputs are active low: one is held low while the line voltage is negative, the other while it is positive. Near the upward crossing the negative-side signal releases shortly before the positive-side signal engages. The block stamps both instants against its own free-running 16-bit timebase and reports the midpoint of the two stamps as the crossing time.

Noise that makes the detectors chatter is rejected by ordering. A result is produced only when a release of the negative-side detector is followed by an engagement of the positive-side detector. A second edge that arrives too late, after a programmable number of timer ticks, is also discarded. The result goes to a downstream phase tracker as a one-cycle strobe with the time held alongside it. The same timebase is exported, so that later stages can schedule events on the same clock.

Top module: `zero_cross_estimator`

## Requirements
- R1: While rst_ni is low, time_o, zc_time_o and zc_valid_o are all zero.
- R2: time_o increases by exactly one, modulo 2^16, every TICK_DIV clock cycles and never changes otherwise.
- R3: A rising edge on neg_n_i (line leaving the negative half) arms the block and captures the time_o value shown in the third clock cycle after the input changes, which accounts for two synchronizer stages and one edge register.
- R4: A falling edge on pos_n_i that is captured while the block is armed yields zc_valid_o high one clock cycle after that capture. zc_time_o then equals first + ((second - first) >> 1) modulo 2^16.
- R5: The midpoint is correct when the timebase wraps between the two captures.
- R6: A falling edge on pos_n_i while the block is not armed produces no result.
- R7: A further rising edge on neg_n_i while the block is armed replaces the first capture, so the result uses the latest one.
- R8: After a result the block disarms, so that further pos_n_i falling edges without a new neg_n_i rising edge produce no result.
- R9: If second - first exceeds timeout_i (in timer ticks), the capture is discarded and no result follows. A difference equal to timeout_i is still accepted.
- R10: zc_valid_o is high for exactly one cycle per result, and zc_time_o changes only on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| neg_n_i | input | 1 | Negative-half detector, low while line is negative (asynchronous) |
| pos_n_i | input | 1 | Positive-half detector, low while line is positive (asynchronous) |
| timeout_i | input | 16 | Maximum ticks allowed between the two captures |
| time_o | output | 16 | Free-running timebase value |
| zc_valid_o | output | 1 | One-cycle strobe for a new crossing time |
| zc_time_o | output | 16 | Estimated crossing time, held between strobes |

## Verification
The case hardest to reach from the ports is a capture pair that straddles the wrap of the 16-bit timebase, combined with the exact timeout boundary. The bench sets the prescaler to one tick per clock and polls time_o until it is a few ticks short of the wrap before it launches a pair. The timeout boundary is hit by placing the second edge exactly timeout_i and timeout_i+1 clocks after the first. Every expected stamp is read from time_o in the cycle in which the synchronized edge is registered.

// File: rtl/zc_est_pkg.sv
package zc_est_pkg;
  localparam int unsigned TIME_W = 16;
  typedef logic [TIME_W-1:0] stamp_t;
  typedef enum logic {ST_IDLE, ST_ARMED} pair_state_e;
endpackage

// File: rtl/zc_timebase.sv
module zc_timebase
  import zc_est_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output stamp_t time_o
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic   tick;
  stamp_t time_q;

  generate
    if (TICK_DIV == 1) begin : g_direct
      assign tick = 1'b1;
    end else begin : g_div
      logic [DIV_W-1:0] div_q;
      assign tick = (div_q == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   time_q <= '0;
    else if (tick) time_q <= time_q + 1'b1;
  end

  assign time_o = time_q;
endmodule

// File: rtl/zc_sync_edge.sv
module zc_sync_edge #(
  parameter int unsigned STAGES = 2,
  parameter bit          RISE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  // reset to the post-edge level so no edge is reported out of reset
  localparam logic IDLE_LVL = RISE;

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{IDLE_LVL}};
      last_q <= IDLE_LVL;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = sync_q[STAGES-1] & ~last_q;
    end else begin : g_fall
      assign edge_o = ~sync_q[STAGES-1] & last_q;
    end
  endgenerate
endmodule

// File: rtl/zc_pair_fsm.sv
module zc_pair_fsm
  import zc_est_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   first_edge_i,
  input  logic   second_edge_i,
  input  stamp_t time_i,
  input  stamp_t timeout_i,
  output logic   armed_o,
  output stamp_t first_o,
  output logic   valid_o,
  output stamp_t zc_time_o
);
  pair_state_e state_q;
  stamp_t      first_q, zc_q, elapsed, mid;
  logic        valid_q, late;

  assign elapsed = time_i - first_q;          // modulo 2^16
  assign late    = elapsed > timeout_i;
  assign mid     = first_q + (elapsed >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      first_q <= '0;
      zc_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (first_edge_i) begin
            first_q <= time_i;
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (second_edge_i && !late) begin
            zc_q    <= mid;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (first_edge_i) begin
            first_q <= time_i;                // latest release wins
          end else if (late || second_edge_i) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign armed_o   = (state_q == ST_ARMED);
  assign first_o   = first_q;
  assign valid_o   = valid_q;
  assign zc_time_o = zc_q;
endmodule

// File: rtl/zero_cross_estimator.sv
module zero_cross_estimator
  import zc_est_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        neg_n_i,
  input  logic        pos_n_i,
  input  logic [15:0] timeout_i,
  output logic [15:0] time_o,
  output logic        zc_valid_o,
  output logic [15:0] zc_time_o
);
  localparam int unsigned N_CH = 2;  // 0: negative side (rise), 1: positive side (fall)

  logic [N_CH-1:0] line_raw, line_edge;
  stamp_t          now;
  logic            pair_armed;
  stamp_t          pair_first;

  assign line_raw = {pos_n_i, neg_n_i};

  zc_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .time_o (now)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    zc_sync_edge #(.STAGES(SYNC_STAGES), .RISE(ch == 0)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_raw[ch]),
      .edge_o (line_edge[ch])
    );
  end

  zc_pair_fsm u_pair (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .first_edge_i  (line_edge[0]),
    .second_edge_i (line_edge[1]),
    .time_i        (now),
    .timeout_i     (timeout_i),
    .armed_o       (pair_armed),
    .first_o       (pair_first),
    .valid_o       (zc_valid_o),
    .zc_time_o     (zc_time_o)
  );

  assign time_o = now;
endmodule

// File: rtl/zero_cross_estimator_chk.sv
module zero_cross_estimator_chk
  import zc_est_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input stamp_t time_o,
  input stamp_t timeout_i,
  input logic   zc_valid_o,
  input stamp_t zc_time_o,
  input logic   second_edge_i,
  input logic   armed_i,
  input stamp_t first_i
);
  // R2
  timer_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_o == $past(time_o)) || (time_o == stamp_t'($past(time_o) + 1'b1)));

  // R4
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_valid_o |-> ($past(second_edge_i) && $past(armed_i)));

  // R9
  late_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && (stamp_t'(time_o - first_i) > timeout_i)) |=> !zc_valid_o);

  // R10
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_valid_o |=> !zc_valid_o);

  // R10
  zc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_valid_o |-> $stable(zc_time_o));
endmodule

bind zero_cross_estimator zero_cross_estimator_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .time_o        (time_o),
  .timeout_i     (timeout_i),
  .zc_valid_o    (zc_valid_o),
  .zc_time_o     (zc_time_o),
  .second_edge_i (line_edge[1]),
  .armed_i       (pair_armed),
  .first_i       (pair_first)
);

// File: tb/test_zero_cross_estimator.sv
`timescale 1ns/1ps
module test_zero_cross_estimator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        neg_n = 1'b0;
  logic        pos_n = 1'b1;
  logic [15:0] timeout = 16'hFFFF;
  logic [15:0] time_o, zc_time_o;
  logic        zc_valid_o;

  int n_chk = 0, n_fail = 0, vcount = 0;
  logic [15:0] last_zc = '0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  zero_cross_estimator #(.TICK_DIV(1)) i_zero_cross_estimator (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .neg_n_i    (neg_n),
    .pos_n_i    (pos_n),
    .timeout_i  (timeout),
    .time_o     (time_o),
    .zc_valid_o (zc_valid_o),
    .zc_time_o  (zc_time_o)
  );

  always @(negedge clk_i) if (zc_valid_o) begin
    vcount++;
    last_zc = zc_time_o;
  end

  // gap between first and second edge in clocks, timeout, expected result count
  localparam logic [15:0] VEC [7][3] = '{
    '{16'd1,   16'd100,  16'd1},
    '{16'd2,   16'd100,  16'd1},
    '{16'd7,   16'd100,  16'd1},
    '{16'd40,  16'd100,  16'd1},
    '{16'd100, 16'd100,  16'd1},
    '{16'd101, 16'd100,  16'd0},
    '{16'd301, 16'd1000, 16'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stamp(output logic [15:0] t);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    t = time_o;
  endtask

  task automatic run_pair(input int gap, output logic [15:0] a, output logic [15:0] b);
    @(negedge clk_i);
    neg_n = 1'b1;
    fork
      stamp(a);
      begin
        repeat (gap) @(negedge clk_i);
        pos_n = 1'b0;
        stamp(b);
      end
    join
  endtask

  task automatic line_down();
    @(negedge clk_i); pos_n = 1'b1;
    repeat (3) @(negedge clk_i); neg_n = 1'b0;
    repeat (5) @(negedge clk_i);
  endtask

  function automatic logic [15:0] midpt(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] d;
    d = b - a;
    return a + (d >> 1);
  endfunction

  initial begin
    logic [15:0] a, b, t0, exp_mid;
    int v0;
    repeat (3) @(negedge clk_i);
    // R1
    check(time_o == 0 && zc_time_o == 0 && zc_valid_o == 0, "R1 reset state",
          {time_o, zc_time_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t0 = time_o;
    @(negedge clk_i);
    // R2
    check(time_o == t0 + 16'd1, "R2 timer step", time_o, t0 + 16'd1);

    // R6: second edge with nothing armed
    v0 = vcount;
    @(negedge clk_i); pos_n = 1'b0;
    repeat (8) @(negedge clk_i);
    check(vcount == v0, "R6 unarmed second edge", vcount - v0, 0);
    pos_n = 1'b1;
    repeat (5) @(negedge clk_i);

    // table walk: R3, R4, R9
    foreach (VEC[i]) begin
      timeout = VEC[i][1];
      v0 = vcount;
      run_pair(int'(VEC[i][0]), a, b);
      check(b - a == VEC[i][0], "R3 capture spacing", b - a, VEC[i][0]);
      @(negedge clk_i);
      if (VEC[i][2] != 0)
        check(zc_valid_o == 1'b1, "R4 strobe timing", zc_valid_o, 1);
      repeat (3) @(negedge clk_i);
      check(vcount - v0 == int'(VEC[i][2]), "R9 accept/discard", vcount - v0, VEC[i][2]);
      if (VEC[i][2] != 0) begin
        exp_mid = midpt(a, b);
        check(last_zc == exp_mid, "R4 midpoint", last_zc, exp_mid);
      end
      line_down();
    end
    timeout = 16'hFFFF;

    // R8: repeated second edge after a result
    run_pair(5, a, b);
    repeat (4) @(negedge clk_i);
    v0 = vcount;
    pos_n = 1'b1;
    repeat (4) @(negedge clk_i); pos_n = 1'b0;
    repeat (8) @(negedge clk_i);
    check(vcount == v0, "R8 no second result", vcount - v0, 0);
    line_down();

    // R7: re-arm replaces the first capture
    @(negedge clk_i); neg_n = 1'b1;
    repeat (6) @(negedge clk_i); neg_n = 1'b0;
    repeat (6) @(negedge clk_i);
    v0 = vcount;
    run_pair(9, a, b);
    repeat (4) @(negedge clk_i);
    exp_mid = midpt(a, b);
    check(vcount - v0 == 1, "R7 single result", vcount - v0, 1);
    check(last_zc == exp_mid, "R7 latest capture used", last_zc, exp_mid);

    // R10: output held between strobes
    repeat (12) @(negedge clk_i);
    check(zc_time_o == exp_mid, "R10 hold", zc_time_o, exp_mid);
    check(zc_valid_o == 1'b0, "R10 strobe low", zc_valid_o, 0);
    line_down();

    // R5: pair straddling timer wrap
    while (time_o != 16'hFFF4) @(negedge clk_i);
    v0 = vcount;
    run_pair(20, a, b);
    repeat (4) @(negedge clk_i);
    exp_mid = midpt(a, b);
    check(b < a, "R5 wrap between stamps", b, a);
    check(vcount - v0 == 1, "R5 result count", vcount - v0, 1);
    check(last_zc == exp_mid, "R5 wrapped midpoint", last_zc, exp_mid);
    line_down();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule